// File: doc/BRIEF.md
# Bridge Window Register Bank

This block is the software-visible register file of a host-to-PCI bridge's inbound address windows. It keeps four windows, each described by a base register, a mask register and a translated-base register. All twelve values drive out continuously as flat parallel buses, so a separate translator can use them without going through the register port.

A single bus slave port reaches the bank. Each request carries an address, a write flag, an access-size code and write data. The bank claims an address only when it lies inside its own range. For each claimed request it returns an acknowledge one clock later, together with an error flag and read data.

Registers sit on 64-byte slots, and only full 64-bit accesses are legal. Two control slots read as zero and swallow writes: the bridge control slot and the slot that invalidates the whole scatter-gather translation cache. Every other slot outside the twelve window registers answers with an error.

Top module: `hbw_regbank`

## Requirements
- R1: The slot index is (req_addr - BASE_ADDR) >> 6, taken over a bank of 32 slots. Address bits [5:0] are ignored. Window w's base is at slot w, its mask at slot 4+w, and its translated base at slot 8+w.
- R2: req_size encodes 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. A claimed request with any code other than 3 is acknowledged with rsp_err=1, and stores nothing.
- R3: The twelve window registers are readable and writable with 64-bit accesses, and they reset to zero.
- R4: Slot 12 (bridge control) reads as zero without error. A write to it is acknowledged without error and changes nothing.
- R5: Slot 19 (invalidate whole translation cache) reads as zero without error. A write to it is acknowledged without error and is discarded.
- R6: Slots 13 to 18, 20 and 21 are unimplemented. Reads and writes to them are acknowledged with rsp_err=1 and store nothing.
- R7: Slots 22 to 31 are undecoded. Any access to them is acknowledged with rsp_err=1.
- R8: A claimed request in cycle n gives rsp_ack=1 in cycle n+1, and rsp_ack is 0 in every other cycle. rsp_rdata is zero for writes and for errored requests.
- R9: An address below BASE_ADDR or at or above BASE_ADDR+2048 is not claimed: there is no acknowledge and no state change.
- R10: win_base_o, win_mask_o and win_xlat_o hold window w's registers in bits [64w+63:64w]. A write becomes visible on them at the same clock edge that raises its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Access size code |
| req_wdata | input | 64 | Write data |
| rsp_ack | output | 1 | Request acknowledged |
| rsp_err | output | 1 | Acknowledged request failed |
| rsp_rdata | output | 64 | Read data |
| win_base_o | output | 256 | Window base registers, flattened |
| win_mask_o | output | 256 | Window mask registers, flattened |
| win_xlat_o | output | 256 | Translated base registers, flattened |

## Verification
A write to a window register does two things at one clock edge: it raises the acknowledge, and it changes the parallel output seen by the translator. The bench sends a write and samples both the response and the parallel buses after that edge. It expects the new value there, and the model's old value everywhere else.

Back-to-back write-then-read pairs to the same slot test the same edge from the read side. Random bursts mix legal writes, writes of the wrong size and writes to error slots, and the bench confirms that each rejected write leaves the outputs unchanged in the very cycle it is acknowledged.

// File: rtl/hbw_pkg.sv
// Package: shared slot classes and size encoding for the bridge window bank.
// Assumes: a single 64-bit register port; slot layout is fixed relative to NUM_WIN.
package hbw_pkg;

    // Classification of the addressed slot
    typedef enum logic [2:0] {
        SLOT_WBASE = 3'd0,
        SLOT_WMASK = 3'd1,
        SLOT_XLAT  = 3'd2,
        SLOT_RAZ   = 3'd3,
        SLOT_BAD   = 3'd4
    } slot_kind_e;

    // Only the full-width access code is legal
    localparam logic [1:0] SIZE_B64 = 2'd3;

    // Control slots follow the three window groups
    localparam int CTRL_OFS   = 0;   // bridge control, read as zero
    localparam int TLBALL_OFS = 7;   // whole-cache invalidate, read as zero
    // Offsets 1..6, 8, 9 after the groups are unimplemented; the rest are undecoded

endpackage

// File: rtl/hbw_decode.sv
// Module: hbw_decode
// Purpose: turns a request address into a claim flag, a slot class and a window
// select. Pure combinational logic.
// Assumes: SLOT_SHIFT + IDX_W < ADDR_W, and the bank does not wrap past the top of
// the address space.
module hbw_decode
    import hbw_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
    parameter int          SLOT_SHIFT = 6,
    parameter int          IDX_W      = 5,
    parameter int          NUM_WIN    = 4,
    parameter int          WSEL_W     = 2
) (
    input  logic [ADDR_W-1:0] req_addr,
    output logic              hit,
    output slot_kind_e        kind,
    output logic [WSEL_W-1:0] wsel
);
    localparam int HI_LSB    = SLOT_SHIFT + IDX_W;
    localparam int GRP2      = 2 * NUM_WIN;
    localparam int GRP3      = 3 * NUM_WIN;
    localparam int CTRL_SLOT = GRP3 + CTRL_OFS;
    localparam int TLB_SLOT  = GRP3 + TLBALL_OFS;

    logic [ADDR_W-1:0] offset;
    logic [IDX_W-1:0]  idx;
    int                idx_i;
    logic              unused_low;

    // Offset from bank base and claim decision
    always_comb begin
        offset = req_addr - ADDR_W'(BASE_ADDR);
        hit    = (req_addr >= ADDR_W'(BASE_ADDR)) && (offset[ADDR_W-1:HI_LSB] == '0);
        idx    = offset[SLOT_SHIFT +: IDX_W];
        idx_i  = int'(idx);
    end

    assign unused_low = ^offset[SLOT_SHIFT-1:0];

    // Slot classification and window select
    always_comb begin
        kind = SLOT_BAD;
        wsel = '0;
        if (idx_i < NUM_WIN) begin
            kind = SLOT_WBASE;
            wsel = WSEL_W'(idx_i);
        end else if (idx_i < GRP2) begin
            kind = SLOT_WMASK;
            wsel = WSEL_W'(idx_i - NUM_WIN);
        end else if (idx_i < GRP3) begin
            kind = SLOT_XLAT;
            wsel = WSEL_W'(idx_i - GRP2);
        end else if (idx_i == CTRL_SLOT || idx_i == TLB_SLOT) begin
            kind = SLOT_RAZ;
        end
    end

endmodule

// File: rtl/hbw_win_regs.sv
// Module: hbw_win_regs
// Purpose: the storage for NUM_WIN windows (base, mask, translated base), one
// write port, a read mux and flat parallel outputs.
// Assumes: wr_en is asserted only for legal full-width writes to stored slots.
module hbw_win_regs
    import hbw_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int DATA_W  = 64,
    parameter int WSEL_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  slot_kind_e                kind,
    input  logic [WSEL_W-1:0]         sel,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [DATA_W-1:0]         rd_data,
    output logic [NUM_WIN*DATA_W-1:0] base_flat,
    output logic [NUM_WIN*DATA_W-1:0] mask_flat,
    output logic [NUM_WIN*DATA_W-1:0] xlat_flat
);
    logic [DATA_W-1:0] base_q [NUM_WIN];
    logic [DATA_W-1:0] mask_q [NUM_WIN];
    logic [DATA_W-1:0] xlat_q [NUM_WIN];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic hit_w;
        assign hit_w = wr_en && (int'(sel) == w);

        // Window base register, cleared by reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q[w] <= '0;
            else if (hit_w && kind == SLOT_WBASE)
                base_q[w] <= wr_data;
        end

        // Window mask register, cleared by reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[w] <= '0;
            else if (hit_w && kind == SLOT_WMASK)
                mask_q[w] <= wr_data;
        end

        // Translated base register, cleared by reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                xlat_q[w] <= '0;
            else if (hit_w && kind == SLOT_XLAT)
                xlat_q[w] <= wr_data;
        end

        assign base_flat[w*DATA_W +: DATA_W] = base_q[w];
        assign mask_flat[w*DATA_W +: DATA_W] = mask_q[w];
        assign xlat_flat[w*DATA_W +: DATA_W] = xlat_q[w];
    end

    // Read mux: stored slots return contents, everything else zero
    always_comb begin
        unique case (kind)
            SLOT_WBASE: rd_data = base_q[sel];
            SLOT_WMASK: rd_data = mask_q[sel];
            SLOT_XLAT:  rd_data = xlat_q[sel];
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/hbw_rsp.sv
// Module: hbw_rsp
// Purpose: registers the single-cycle response (acknowledge, error, read data).
// Assumes: the inputs are valid in the same cycle as the claimed request.
module hbw_rsp #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              err_d,
    input  logic [DATA_W-1:0] rdata_d,
    output logic              ack_q,
    output logic              err_q,
    output logic [DATA_W-1:0] rdata_q
);
    // Response flops; idle cycles return a clean zero response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q   <= fire;
            err_q   <= fire && err_d;
            rdata_q <= fire ? rdata_d : '0;
        end
    end

endmodule

// File: rtl/hbw_regbank.sv
// Module: hbw_regbank (top)
// Purpose: the window register bank of a host-to-PCI bridge. It decodes 64-byte
// slots, checks the access size, stores window registers, answers the read-as-zero
// control slots and returns an error for every other slot.
// Assumes: one request per cycle at most; no back-pressure; responses one cycle later.
module hbw_regbank
    import hbw_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 64,
    parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
    parameter int          SLOT_SHIFT = 6,
    parameter int          IDX_W      = 5,
    parameter int          NUM_WIN    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [1:0]                req_size,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      rsp_ack,
    output logic                      rsp_err,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic [NUM_WIN*DATA_W-1:0] win_base_o,
    output logic [NUM_WIN*DATA_W-1:0] win_mask_o,
    output logic [NUM_WIN*DATA_W-1:0] win_xlat_o
);
    localparam int WSEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic              hit;
    slot_kind_e        kind;
    logic [WSEL_W-1:0] wsel;
    logic              stored;
    logic              err_now;
    logic              fire;
    logic              wr_en;
    logic [DATA_W-1:0] reg_rd;
    logic [DATA_W-1:0] rdata_now;

    hbw_decode #(
        .ADDR_W     (ADDR_W),
        .BASE_ADDR  (BASE_ADDR),
        .SLOT_SHIFT (SLOT_SHIFT),
        .IDX_W      (IDX_W),
        .NUM_WIN    (NUM_WIN),
        .WSEL_W     (WSEL_W)
    ) u_dec (
        .req_addr (req_addr),
        .hit      (hit),
        .kind     (kind),
        .wsel     (wsel)
    );

    // Request qualification: claim, error and write enable
    always_comb begin
        stored    = (kind == SLOT_WBASE) || (kind == SLOT_WMASK) || (kind == SLOT_XLAT);
        fire      = req_valid && hit;
        err_now   = (req_size != SIZE_B64) || (kind == SLOT_BAD);
        wr_en     = fire && req_write && !err_now && stored;
        rdata_now = (!req_write && !err_now) ? reg_rd : '0;
    end

    hbw_win_regs #(
        .NUM_WIN (NUM_WIN),
        .DATA_W  (DATA_W),
        .WSEL_W  (WSEL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .kind      (kind),
        .sel       (wsel),
        .wr_data   (req_wdata),
        .rd_data   (reg_rd),
        .base_flat (win_base_o),
        .mask_flat (win_mask_o),
        .xlat_flat (win_xlat_o)
    );

    hbw_rsp #(
        .DATA_W (DATA_W)
    ) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .err_d   (err_now),
        .rdata_d (rdata_now),
        .ack_q   (rsp_ack),
        .err_q   (rsp_err),
        .rdata_q (rsp_rdata)
    );

endmodule

// File: rtl/hbw_regbank_chk.sv
// Module: hbw_regbank_chk
// Purpose: protocol and behaviour properties of hbw_regbank, bound to every instance.
// Assumes: the same parameters as the bound instance.
module hbw_regbank_chk #(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 64,
    parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
    parameter int          SLOT_SHIFT = 6,
    parameter int          IDX_W      = 5,
    parameter int          NUM_WIN    = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_write,
    input logic [ADDR_W-1:0]         req_addr,
    input logic [1:0]                req_size,
    input logic                      rsp_ack,
    input logic                      rsp_err,
    input logic [DATA_W-1:0]         rsp_rdata,
    input logic [NUM_WIN*DATA_W-1:0] win_base_o,
    input logic [NUM_WIN*DATA_W-1:0] win_mask_o,
    input logic [NUM_WIN*DATA_W-1:0] win_xlat_o
);
    localparam int HI_LSB = SLOT_SHIFT + IDX_W;
    localparam int CTRL   = 3 * NUM_WIN;

    logic [ADDR_W-1:0] c_off;
    logic              c_hit;
    logic [IDX_W-1:0]  c_idx;

    // Independent claim computation from the port values
    always_comb begin
        c_off = req_addr - ADDR_W'(BASE_ADDR);
        c_hit = (req_addr >= ADDR_W'(BASE_ADDR)) && (c_off[ADDR_W-1:HI_LSB] == '0);
        c_idx = c_off[SLOT_SHIFT +: IDX_W];
    end

    p_ack_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && c_hit) |=> rsp_ack);

    p_no_claim_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || !c_hit) |=> !rsp_ack);

    p_size_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && c_hit && req_size != 2'd3) |=> rsp_err);

    p_err_with_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_ack);

    p_err_zero_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));

    p_ctrl_raz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && c_hit && req_size == 2'd3 && int'(c_idx) == CTRL)
        |=> (!rsp_err && rsp_rdata == '0));

    p_hold_outputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && c_hit)
        |=> ($stable(win_base_o) && $stable(win_mask_o) && $stable(win_xlat_o)));

endmodule

bind hbw_regbank hbw_regbank_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .BASE_ADDR  (BASE_ADDR),
    .SLOT_SHIFT (SLOT_SHIFT),
    .IDX_W      (IDX_W),
    .NUM_WIN    (NUM_WIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .rsp_ack    (rsp_ack),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .win_base_o (win_base_o),
    .win_mask_o (win_mask_o),
    .win_xlat_o (win_xlat_o)
);

// File: tb/tb_hbw_regbank.sv
// Bench for hbw_regbank: directed corner cases followed by seeded random traffic,
// checked against a register model in the bench.
module tb_hbw_regbank;

    localparam logic [31:0] BASE = 32'h4000_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [1:0]   req_size = 2'd3;
    logic [63:0]  req_wdata = '0;
    logic         rsp_ack;
    logic         rsp_err;
    logic [63:0]  rsp_rdata;
    logic [255:0] win_base_o;
    logic [255:0] win_mask_o;
    logic [255:0] win_xlat_o;

    int n_chk = 0;
    int n_err = 0;
    logic [63:0] model [12];

    always #5 clk = ~clk;

    hbw_regbank dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_wdata  (req_wdata),
        .rsp_ack    (rsp_ack),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata),
        .win_base_o (win_base_o),
        .win_mask_o (win_mask_o),
        .win_xlat_o (win_xlat_o)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit slot_err(int idx, logic [1:0] sz);
        return (sz != 2'd3) || !(idx < 13 || idx == 19);
    endfunction

    function automatic string slot_tag(int idx, logic [1:0] sz, bit inr);
        if (!inr) return "R9";
        if (sz != 2'd3) return "R2";
        if (idx < 12) return "R3";
        if (idx == 12) return "R4";
        if (idx == 19) return "R5";
        if (idx < 22) return "R6";
        return "R7";
    endfunction

    // Compare every parallel output against the model
    task automatic chk_outputs(string tag);
        for (int w = 0; w < 4; w++) begin
            chk(tag, "base out", win_base_o[w*64 +: 64], model[w]);
            chk(tag, "mask out", win_mask_o[w*64 +: 64], model[4+w]);
            chk(tag, "xlat out", win_xlat_o[w*64 +: 64], model[8+w]);
        end
    endtask

    // One request issued at a negedge; response sampled at the next negedge
    task automatic op(bit wr, logic [31:0] a, logic [1:0] sz, logic [63:0] d);
        logic [31:0] off;
        bit          inr;
        int          idx;
        bit          e;
        logic [63:0] exp_rd;
        string       tag;
        off = a - BASE;
        inr = (a >= BASE) && (off < 32'd2048);
        idx = int'(off[10:6]);
        e   = slot_err(idx, sz);
        tag = slot_tag(idx, sz, inr);
        exp_rd = (inr && !wr && !e && idx < 12) ? model[idx] : 64'd0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        if (inr && wr && !e && idx < 12) model[idx] = d;
        chk(tag, "ack", {63'd0, rsp_ack}, {63'd0, inr});
        if (inr) begin
            chk(tag, "err", {63'd0, rsp_err}, {63'd0, e});
            chk(tag, "rdata", rsp_rdata, exp_rd);
        end
        chk((wr && inr) ? "R10" : tag, "outputs", 64'd0, 64'd0);
        chk_outputs(wr ? "R10" : tag);
        req_valid = 1'b0;
    endtask

    function automatic logic [31:0] slot_addr(int idx, int low);
        return BASE + 32'(idx * 64 + low);
    endfunction

    // Watchdog: a hung run is a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 12; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state and idle response (R8)
        chk("R8", "idle ack", {63'd0, rsp_ack}, 64'd0);
        chk_outputs("R3");

        // R1: low address bits ignored, layout of groups
        op(1'b1, slot_addr(0, 42), 2'd3, 64'hA5A5_0000_1111_2222);
        op(1'b0, slot_addr(0, 0), 2'd3, '0);
        op(1'b1, slot_addr(5, 63), 2'd3, 64'h0000_0000_FFF0_0000);
        chk("R1", "mask window 1", win_mask_o[64 +: 64], 64'h0000_0000_FFF0_0000);

        // R3, R10: every stored register, write then read back-to-back
        for (int i = 0; i < 12; i++) begin
            op(1'b1, slot_addr(i, 0), 2'd3, {32'hC0DE_0000 | 32'(i), 32'(i * 7 + 1)});
            op(1'b0, slot_addr(i, 8), 2'd3, '0);
        end

        // R2: narrow accesses rejected and store nothing
        for (int s = 0; s < 3; s++) begin
            op(1'b1, slot_addr(5, 0), 2'(s), 64'hDEAD_BEEF_DEAD_BEEF);
            op(1'b0, slot_addr(5, 0), 2'(s), '0);
        end
        op(1'b0, slot_addr(5, 0), 2'd3, '0);

        // R4: control slot reads zero, writes ignored
        op(1'b1, slot_addr(12, 0), 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        op(1'b0, slot_addr(12, 0), 2'd3, '0);

        // R5: whole-cache invalidate slot accepts and discards
        op(1'b1, slot_addr(19, 0), 2'd3, 64'h1234_5678_9ABC_DEF0);
        op(1'b0, slot_addr(19, 0), 2'd3, '0);

        // R6: unimplemented slots error both ways
        for (int i = 13; i < 22; i++) begin
            if (i != 19) begin
                op(1'b1, slot_addr(i, 0), 2'd3, 64'h5555);
                op(1'b0, slot_addr(i, 0), 2'd3, '0);
            end
        end

        // R7: undecoded slots
        op(1'b0, slot_addr(22, 0), 2'd3, '0);
        op(1'b1, slot_addr(31, 56), 2'd3, 64'h77);

        // R9: outside the bank on either side
        op(1'b1, BASE - 32'd8, 2'd3, 64'h9999);
        op(1'b0, BASE + 32'd2048, 2'd3, '0);
        op(1'b1, BASE + 32'd4096, 2'd3, 64'h8888);

        // R8: idle cycle gives no acknowledge
        @(negedge clk);
        chk("R8", "idle ack", {63'd0, rsp_ack}, 64'd0);

        // Random mix of slots, sizes, directions and out-of-range addresses
        for (int k = 0; k < 600; k++) begin
            int          pick;
            int          idx;
            logic [1:0]  sz;
            logic [31:0] a;
            pick = int'($urandom_range(0, 99));
            idx  = (pick < 60) ? int'($urandom_range(0, 11)) : int'($urandom_range(0, 31));
            sz   = ($urandom_range(0, 9) < 8) ? 2'd3 : 2'($urandom_range(0, 2));
            if (pick >= 95)
                a = (pick[0]) ? BASE - 32'($urandom_range(1, 512))
                              : BASE + 32'd2048 + 32'($urandom_range(0, 512));
            else
                a = slot_addr(idx, int'($urandom_range(0, 63)));
            op($urandom_range(0, 1) == 1, a, sz, {$urandom, $urandom});
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule